// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port with Status/Control Register Pair

This block is a byte-wide asynchronous serial port seen by a processor through two register addresses, picked by one register-select input. With select low, a read returns a status byte and a write goes to a control byte. With select high, a write hands a byte to the transmitter and a read takes the oldest received byte. Received bytes are kept in a 16-entry first-in first-out buffer. Software polls the receive-ready flag before it reads data, and polls the transmit-empty flag before it writes data.

Bit timing comes from a single-cycle enable input, `tick16`, that pulses at sixteen times the baud rate. Frames have one start bit, eight data bits sent least significant bit first, and one stop bit. Two active-low lines give hardware flow control. `n_rts` asks the far end to send only while the buffer has room. `n_cts` holds back the transmitter while the far end is not ready. Register and strobe accesses are synchronous to `clk`: each clock cycle in which a strobe is low counts as one access.

Receiver states: RX_IDLE, RX_START, RX_DATA and RX_STOP. RX_IDLE goes to RX_START on a tick that sees the line fall from 1 to 0. RX_START goes back to RX_IDLE if the line is high on the 8th tick, and otherwise goes to RX_DATA. RX_DATA samples one bit every 16 ticks and goes to RX_STOP after the 8th bit. RX_STOP goes to RX_IDLE after 16 ticks, and stores the byte only if the stop sample is 1. Transmitter states: TX_IDLE, TX_START, TX_DATA and TX_STOP. TX_IDLE goes to TX_START when a byte is held and `n_cts` is low, and moves the held byte into the shifter. Each of the other states lasts 16 ticks per bit, and TX_STOP returns to TX_IDLE. A master reset sends both machines to their idle state from any state.

Top module: `sio_unit`

## Requirements
- R1: After reset the status byte reads 0x02. Bit 0 is rx_ready, bit 1 is tx_empty, bit 2 (carrier missing) and bit 3 (clear-to-send inactive) always read 0, bits 6:4 read 0, and bit 7 is the interrupt flag. After reset `txd` is 1.
- R2: A control write whose bits 1:0 are not 11 stores bits 6:5 as the transmit mode and bit 7 as the interrupt enable. Mode encoding: 00 = RTS active with tx interrupt off; 01 = RTS active with tx interrupt on; 10 = RTS inactive with tx interrupt off; 11 = RTS active with tx interrupt off.
- R3: A control write with bits 1:0 = 11 is a master reset. It empties the receive buffer, abandons any frame being sent or received, drops a held transmit byte, and sets the mode to 00 with interrupts disabled.
- R4: rx_ready is 1 exactly when the buffer is not empty. A data read returns the oldest byte and removes it.
- R5: The buffer holds 16 bytes. A byte that completes while the buffer is full is discarded, and the 16 stored bytes are kept in order.
- R6: The receiver takes 8N1 frames least significant bit first and samples each bit 8 ticks after its start. A frame whose stop sample is 0 is discarded.
- R7: A low pulse on `rxd` that has returned high by the 8th tick after the falling edge is ignored.
- R8: A data write while tx_empty is 1 sends that byte as a start bit 0, eight data bits least significant bit first and a stop bit 1, each 16 ticks long. tx_empty returns to 1 as soon as the byte moves into the shifter.
- R9: A data write while tx_empty is 0 is ignored. The held byte is kept and sent unchanged.
- R10: While `n_cts` is high, no new frame starts and `txd` stays 1.
- R11: `n_rts` is 0 only when the mode is not 10 and the buffer has at least 2 free entries.
- R12: The interrupt flag is 1 when interrupts are enabled and either rx_ready is 1, or the mode is 01 and tx_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_wr | input | 1 | Active-low write strobe, one access per low cycle |
| n_rd | input | 1 | Active-low read strobe, one access per low cycle |
| reg_sel | input | 1 | 0 = status/control, 1 = data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data: status byte or oldest received byte |
| tick16 | input | 1 | Single-cycle enable at 16 times the baud rate |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| n_rts | output | 1 | Active-low request to send |
| n_cts | input | 1 | Active-low clear to send |

## Verification
The assertions assume three things about the inputs. `tick16` is a single-cycle pulse that arrives no more often than every other clock. Each strobe is low for exactly the cycles meant as accesses. `rxd` frames hold every bit for 16 ticks. The bench produces `tick16` from a fixed divide-by-four counter. It drives each strobe low for exactly one clock, starting and ending at falling edges. It builds each serial bit on `rxd` as 64 clocks, which is 16 ticks, and changes `n_cts` only while the transmitter is idle or waiting on it.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    // Transmit-mode field decode: only 10 releases RTS
    function automatic logic mode_rts_on(input logic [1:0] mode);
        return (mode != 2'b10);
    endfunction

    // Transmit-mode field decode: only 01 enables the tx interrupt
    function automatic logic mode_txirq_on(input logic [1:0] mode);
        return (mode == 2'b01);
    endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [$clog2(DEPTH):0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign count   = wr_ptr - rd_ptr;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (push && full && !pop && !clr) |=> count == $past(count)); // R5
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (pop && !push && !empty && !clr) |=> count == $past(count) - 1'b1); // R4

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          rxd,
    output logic          push,
    output logic [DW-1:0] rx_byte
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DW);
    localparam int HALF  = OVS / 2;

    rx_state_t        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [BIT_W-1:0] bitc, bitc_n;
    logic [DW-1:0]    sh, sh_n;
    logic             rx_meta, rxs, prev;

    // two-flop synchroniser and tick-rate edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rxs     <= 1'b1;
            prev    <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rxs     <= rx_meta;
            if (clr)       prev <= 1'b1;
            else if (tick) prev <= rxs;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bitc <= '0;
            sh   <= '0;
        end else if (clr) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bitc <= '0;
            sh   <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            bitc <= bitc_n;
            sh   <= sh_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        bitc_n = bitc;
        sh_n   = sh;
        unique case (st)
            RX_IDLE: begin
                if (tick && prev && !rxs) begin
                    st_n  = RX_START;
                    cnt_n = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == CNT_W'(HALF - 1)) begin
                        if (!rxs) begin
                            st_n   = RX_DATA;
                            cnt_n  = '0;
                            bitc_n = '0;
                        end else begin
                            st_n = RX_IDLE;
                        end
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == CNT_W'(OVS - 1)) begin
                        sh_n   = {rxs, sh[DW-1:1]};
                        bitc_n = bitc + 1'b1;
                        if (bitc == BIT_W'(DW - 1)) st_n = RX_STOP;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == CNT_W'(OVS - 1)) st_n = RX_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        push    = (st == RX_STOP) && tick && (cnt == CNT_W'(OVS - 1)) && rxs && !clr;
        rx_byte = sh;
    end

    AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n) (st == RX_DATA && $past(st) == RX_START) |-> !$past(rxs)); // R7
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n) push |=> st == RX_IDLE); // R6
    AST_IDLE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n) (st == RX_STOP && $past(st) == RX_DATA) |-> $past(bitc) == BIT_W'(DW - 1)); // R6

endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          n_cts,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    output logic          tx_empty,
    output logic          txd
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DW);

    tx_state_t        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [BIT_W-1:0] bitc, bitc_n;
    logic [DW-1:0]    sh, sh_n;
    logic [DW-1:0]    hold;
    logic             hold_full;
    logic             take;

    assign tx_empty = !hold_full;

    // holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (clr) begin
            hold_full <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (load && !hold_full) begin
            hold      <= wdata;
            hold_full <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            bitc <= '0;
            sh   <= '0;
        end else if (clr) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            bitc <= '0;
            sh   <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            bitc <= bitc_n;
            sh   <= sh_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        bitc_n = bitc;
        sh_n   = sh;
        take   = 1'b0;
        unique case (st)
            TX_IDLE: begin
                if (hold_full && !n_cts) begin
                    st_n  = TX_START;
                    cnt_n = '0;
                    sh_n  = hold;
                    take  = 1'b1;
                end
            end
            TX_START: begin
                if (tick) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == CNT_W'(OVS - 1)) begin
                        st_n   = TX_DATA;
                        bitc_n = '0;
                    end
                end
            end
            TX_DATA: begin
                if (tick) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == CNT_W'(OVS - 1)) begin
                        sh_n   = sh >> 1;
                        bitc_n = bitc + 1'b1;
                        if (bitc == BIT_W'(DW - 1)) st_n = TX_STOP;
                    end
                end
            end
            TX_STOP: begin
                if (tick) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == CNT_W'(OVS - 1)) st_n = TX_IDLE;
                end
            end
        endcase
    end

    // registered line output, driven from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd <= 1'b1;
        end else if (clr) begin
            txd <= 1'b1;
        end else begin
            unique case (st_n)
                TX_IDLE:  txd <= 1'b1;
                TX_START: txd <= 1'b0;
                TX_DATA:  txd <= sh_n[0];
                TX_STOP:  txd <= 1'b1;
            endcase
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) (st == TX_START) |-> !txd); // R8
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (st == TX_IDLE || st == TX_STOP) |-> txd); // R8
    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == TX_IDLE && n_cts && !clr) |=> st == TX_IDLE); // R10
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (load && hold_full && !clr) |=> hold == $past(hold)); // R9

endmodule

// File: rtl/sio_unit.sv
module sio_unit
    import sio_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          n_wr,
    input  logic          n_rd,
    input  logic          reg_sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic          tick16,
    input  logic          rxd,
    output logic          txd,
    output logic          n_rts,
    input  logic          n_cts
);
    // status and control layouts occupy eight bits, so DW must be at least 8
    localparam int CW = $clog2(DEPTH) + 1;

    logic          wr_ctl, wr_dat, rd_dat, mreset;
    logic [1:0]    tx_mode;
    logic          irq_en;
    logic          rx_push;
    logic [DW-1:0] rx_byte, fifo_head;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_full, fifo_empty;
    logic          tx_empty;
    logic          rx_ready, irq;
    logic [DW-1:0] status;
    logic          unused_ctl;

    assign wr_ctl = !n_wr && !reg_sel;
    assign wr_dat = !n_wr && reg_sel;
    assign rd_dat = !n_rd && reg_sel;
    assign mreset = wr_ctl && (din[1:0] == 2'b11);
    assign unused_ctl = ^din[4:2];

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_mode <= 2'b00;
            irq_en  <= 1'b0;
        end else if (mreset) begin
            tx_mode <= 2'b00;
            irq_en  <= 1'b0;
        end else if (wr_ctl) begin
            tx_mode <= din[6:5];
            irq_en  <= din[7];
        end
    end

    sio_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mreset),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rd_dat),
        .head  (fifo_head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mreset),
        .tick    (tick16),
        .rxd     (rxd),
        .push    (rx_push),
        .rx_byte (rx_byte)
    );

    sio_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mreset),
        .tick     (tick16),
        .n_cts    (n_cts),
        .load     (wr_dat),
        .wdata    (din),
        .tx_empty (tx_empty),
        .txd      (txd)
    );

    assign rx_ready = !fifo_empty;
    assign irq      = irq_en && (rx_ready || (mode_txirq_on(tx_mode) && tx_empty));
    assign status   = DW'({irq, 3'b000, 1'b0, 1'b0, tx_empty, rx_ready});
    assign dout     = reg_sel ? fifo_head : status;
    assign n_rts    = !(mode_rts_on(tx_mode) && (fifo_cnt <= CW'(DEPTH - 2)));

    AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> n_rts); // R11
    AST_MRESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) mreset |=> (fifo_empty && tx_empty && !irq_en)); // R3
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!irq_en && !reg_sel) |-> !dout[7]); // R12
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n) !reg_sel |-> dout[6:2] == 5'b00000); // R1

endmodule

// File: tb/test_sio_unit.sv
module test_sio_unit;
    localparam int DEPTH = 16;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       n_wr = 1'b1, n_rd = 1'b1, reg_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       tick16;
    logic       rxd = 1'b1;
    logic       txd, n_rts;
    logic       n_cts = 1'b0;
    logic [1:0] tdiv = 2'd0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_ie = 1'b0;
    logic [1:0] m_mode = 2'b00;
    logic [7:0] q[$];

    always #5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd0);

    sio_unit i_sio_unit (
        .clk(clk), .rst_n(rst_n), .n_wr(n_wr), .n_rd(n_rd), .reg_sel(reg_sel),
        .din(din), .dout(dout), .tick16(tick16), .rxd(rxd), .txd(txd),
        .n_rts(n_rts), .n_cts(n_cts)
    );

    function automatic logic exp_irq(input logic ie, input logic [1:0] mode,
                                     input logic rdy, input logic emp);
        return ie && (rdy || (mode == 2'b01 && emp));
    endfunction

    function automatic logic [7:0] exp_status(input logic rdy, input logic emp);
        return {exp_irq(m_ie, m_mode, rdy, emp), 5'b00000, emp, rdy};
    endfunction

    function automatic logic exp_nrts(input logic [1:0] mode, input int cnt);
        return !((mode != 2'b10) && (cnt <= DEPTH - 2));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; din = v; n_wr = 1'b0;
        @(negedge clk);
        n_wr = 1'b1;
    endtask

    task automatic set_ctl(input logic ie, input logic [1:0] mode);
        wr_reg(1'b0, {ie, mode, 5'b00000});
        m_ie = ie; m_mode = mode;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; n_rd = 1'b0;
        #1 v = dout;
        @(negedge clk);
        n_rd = 1'b1;
    endtask

    task automatic bit_time(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (BITCLK - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(b[i]);
        bit_time(stop_v);
        bit_time(1'b1);
    endtask

    task automatic cap_frame(output logic [7:0] b, output logic stop_v, output logic seen);
        b = 8'h00; stop_v = 1'b0; seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (!txd) seen = 1'b1;
        end
        if (!seen) return;
        repeat (BITCLK / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BITCLK) @(negedge clk);
            b[i] = txd;
        end
        repeat (BITCLK) @(negedge clk);
        stop_v = txd;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, d, b;
        logic stp, seen;
        int lows;
        void'($urandom(32'd4051));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, s);
        chk("R1 reset status", s, 8'h02);
        chk("R1 txd idle", txd, 1);
        chk("R11 n_rts after reset", n_rts, exp_nrts(2'b00, 0));

        // R2 / R11 / R12 mode decode
        set_ctl(1'b0, 2'b10);
        chk("R2 mode 10 releases RTS", n_rts, 1);
        set_ctl(1'b1, 2'b01);
        rd_reg(1'b0, s);
        chk("R12 tx irq when empty", s, exp_status(1'b0, 1'b1));
        set_ctl(1'b1, 2'b11);
        rd_reg(1'b0, s);
        chk("R2 mode 11 no tx irq", s, exp_status(1'b0, 1'b1));
        chk("R2 mode 11 RTS active", n_rts, 0);
        set_ctl(1'b0, 2'b00);

        // R4 / R6 random receive
        for (int k = 0; k < 6; k++) begin
            b = 8'($urandom_range(0, 255));
            send_frame(b, 1'b1);
            q.push_back(b);
            rd_reg(1'b0, s);
            chk("R4 rx_ready after byte", s[0], 1);
        end
        while (q.size() > 0) begin
            rd_reg(1'b1, d);
            chk("R6 received byte in order", d, q.pop_front());
        end
        rd_reg(1'b0, s);
        chk("R4 rx_ready clear after drain", s, exp_status(1'b0, 1'b1));

        // R6 bad stop, R7 glitch
        send_frame(8'hA5, 1'b0);
        rd_reg(1'b0, s);
        chk("R6 bad stop discarded", s[0], 0);
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (800) @(negedge clk);
        rd_reg(1'b0, s);
        chk("R7 short low ignored", s[0], 0);
        send_frame(8'h00, 1'b1);
        send_frame(8'hFF, 1'b1);
        rd_reg(1'b1, d);
        chk("R6 all-zero byte", d, 8'h00);
        rd_reg(1'b1, d);
        chk("R6 all-one byte", d, 8'hFF);

        // R12 rx interrupt
        set_ctl(1'b1, 2'b00);
        send_frame(8'h3C, 1'b1);
        rd_reg(1'b0, s);
        chk("R12 irq from rx_ready", s, exp_status(1'b1, 1'b1));
        rd_reg(1'b1, d);
        chk("R4 pop irq byte", d, 8'h3C);
        set_ctl(1'b0, 2'b00);

        // R5 / R11 fill
        for (int k = 0; k < DEPTH + 1; k++) begin
            b = 8'($urandom_range(0, 255));
            send_frame(b, 1'b1);
            if (k < DEPTH) q.push_back(b);
            if (k == DEPTH - 3) chk("R11 n_rts with two free", n_rts, exp_nrts(m_mode, k + 1));
            if (k == DEPTH - 2) chk("R11 n_rts with one free", n_rts, exp_nrts(m_mode, k + 1));
        end
        chk("R11 n_rts when full", n_rts, 1);
        while (q.size() > 0) begin
            rd_reg(1'b1, d);
            chk("R5 stored byte kept when full", d, q.pop_front());
        end
        rd_reg(1'b0, s);
        chk("R5 overflow byte dropped", s[0], 0);

        // R3 master reset
        send_frame(8'h11, 1'b1);
        set_ctl(1'b1, 2'b10);
        n_cts = 1'b1;
        wr_reg(1'b1, 8'h77);
        wr_reg(1'b0, 8'h03);
        m_ie = 1'b0; m_mode = 2'b00;
        rd_reg(1'b0, s);
        chk("R3 status after master reset", s, 8'h02);
        chk("R3 mode cleared RTS active", n_rts, 0);
        n_cts = 1'b0;
        repeat (200) @(negedge clk);
        chk("R3 held byte dropped", txd, 1);

        // R8 random transmit
        for (int k = 0; k < 5; k++) begin
            b = 8'($urandom_range(0, 255));
            wr_reg(1'b1, b);
            repeat (3) @(negedge clk);
            rd_reg(1'b0, s);
            chk("R8 tx_empty after move to shifter", s[1], 1);
            cap_frame(d, stp, seen);
            chk("R8 frame started", seen, 1);
            chk("R8 data bits", d, b);
            chk("R8 stop bit", stp, 1);
            repeat (40) @(negedge clk);
        end

        // R9 / R10 hold while not clear to send
        n_cts = 1'b1;
        wr_reg(1'b1, 8'hC3);
        repeat (3) @(negedge clk);
        rd_reg(1'b0, s);
        chk("R9 tx_empty low when held", s[1], 0);
        wr_reg(1'b1, 8'h5A);
        lows = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R10 no frame while n_cts high", lows, 0);
        n_cts = 1'b0;
        cap_frame(d, stp, seen);
        chk("R9 held byte sent unchanged", d, 8'hC3);
        lows = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R9 second write ignored", lows, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule